// File: doc/BRIEF.md
# PCIe Root Interrupt Status Aggregator

This block gathers the interrupt sources of one PCIe root complex and turns them into a single level-sensitive interrupt towards the host processor. Four legacy INTx wires are tracked as level status bits. A done bit records the completion of a configuration transaction. A 32-bit doorbell write port carries message-signalled interrupt vector numbers, and each vector sets one pending bit in a bank of two 32-bit words. Software reads these registers through a small register port. Through the same port it writes the enable registers and acknowledges status.

The output line is held by a two-state machine. `IRQ_QUIET` means the line is low and `IRQ_RAISED` means it is high. `QUIET -> RAISED` is taken on an accepted doorbell, or on an INTx level change that leaves an enabled status bit set. `RAISED -> QUIET` is taken on a partial clear of MSI status that empties both pending words, or on an INTx change that leaves no enabled status bit set. No other event moves the machine. In particular, writing INT_EN on its own does not re-evaluate the line.

Register select codes on `reg_addr` are: 0 interrupt enable, 1 interrupt status, 2 MSI enable low word, 3 MSI enable high word, 4 MSI pending low word, 5 MSI pending high word. Codes 6 and 7 read as zero and ignore writes.

Top module: `pirq_aggregator`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: Interrupt status bits 3:0 show the level of `intx_lvl[3:0]` as captured at the previous rising clock edge.
- R3: In a cycle where `intx_lvl` differs from status bits 3:0, `irq` becomes the OR of (new status AND interrupt enable bits 4:0) on the next cycle.
- R4: A doorbell is accepted only when `db_valid` is high, all four `db_be` bits are set, and `db_data` is below 64. Bit 5 of the vector selects the word (0 low, 1 high) and bits 4:0 select the bit to set. An accepted doorbell drives `irq` high on the next cycle. A rejected doorbell changes nothing.
- R5: A write to interrupt status (code 1) clears every written-one bit at position 4 and above, and leaves bits 3:0 untouched. Bit 4 is the transaction-done flag, and a one-cycle pulse on `cfg_done` sets it.
- R6: Writing zero to an MSI pending word (code 4 or 5) changes nothing.
- R7: Writing 0xFFFFFFFF to an MSI pending word clears that word and leaves `irq` unchanged.
- R8: Any other nonzero write to an MSI pending word clears the written-one bits. If both pending words are then zero, `irq` goes low. Otherwise `irq` keeps its value.
- R9: A set event and a software clear of the same bit in the same cycle leave the bit set. This applies to a doorbell against a pending write, and to `cfg_done` against an interrupt status write.
- R10: Events in one cycle are ordered. An accepted doorbell wins over the MSI-empty drop, and the MSI-empty drop wins over the INTx re-evaluation.
- R11: The enable registers read back what was written, and interrupt enable keeps only bits 4:0. A write to an enable register does not change `irq` by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| intx_lvl | input | 4 | Legacy INTx levels A..D |
| cfg_done | input | 1 | Pulse: configuration transaction finished |
| db_valid | input | 1 | Doorbell write strobe |
| db_be | input | 4 | Doorbell byte enables |
| db_data | input | 32 | Doorbell data, the vector number |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select code |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Level interrupt to the host |

## Verification
The bound checker watches several relations on every cycle. Status bits 3:0 must track the INTx levels one cycle late. Every accepted doorbell must raise its pending bit and the line, and nothing else may set a pending bit. A zero write to a pending word must leave it as it was, and an all-ones write must not move the line. The done flag must obey both its set and its clear. The bench scenarios cover what depends on history. These include the line staying low when an enable is written without an INTx change, a partial clear that empties only one of the two words, the same-cycle collisions of set and clear, and the ordering between a doorbell, an MSI drop and an INTx re-evaluation.

// File: rtl/pirq_pkg.sv
`timescale 1ns/1ps
package pirq_pkg;
    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;
endpackage

// File: rtl/pirq_intx_status.sv
`timescale 1ns/1ps
module pirq_intx_status #(
    parameter int NUM_INTX = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_INTX-1:0] intx_lvl,
    input  logic                cfg_done,
    input  logic                clr_done,
    output logic [NUM_INTX:0]   sts_q,
    output logic [NUM_INTX:0]   sts_next,
    output logic                intx_evt
);
    logic done_next;

    // Set wins over a same-cycle software clear (R9)
    assign done_next = (sts_q[NUM_INTX] & ~clr_done) | cfg_done;
    assign sts_next  = {done_next, intx_lvl};
    assign intx_evt  = (intx_lvl != sts_q[NUM_INTX-1:0]);

    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= sts_next;
    end
endmodule

// File: rtl/pirq_msi_pending.sv
`timescale 1ns/1ps
module pirq_msi_pending #(
    parameter int DW        = 32,
    parameter int MSI_WORDS = 2,
    localparam int BIT_W    = $clog2(DW),
    localparam int WSEL_W   = $clog2(MSI_WORDS),
    localparam int VEC_W    = BIT_W + WSEL_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    db_hit,
    input  logic [VEC_W-1:0]        db_vec,
    input  logic [MSI_WORDS-1:0]    pend_wr,
    input  logic [DW-1:0]           wdata,
    output logic [MSI_WORDS*DW-1:0] pend_q,
    output logic                    drop_req
);
    logic [MSI_WORDS*DW-1:0] pend_d;
    logic [MSI_WORDS-1:0]    partial;

    for (genvar w = 0; w < MSI_WORDS; w++) begin : g_word
        logic [DW-1:0] set_m;
        logic [DW-1:0] clr_m;
        assign set_m = (db_hit && (db_vec[VEC_W-1:BIT_W] == WSEL_W'(w)))
                     ? (DW'(1) << db_vec[BIT_W-1:0]) : '0;
        assign clr_m = pend_wr[w] ? wdata : '0;
        assign pend_d[w*DW +: DW] = (pend_q[w*DW +: DW] & ~clr_m) | set_m;
        assign partial[w] = pend_wr[w] && (wdata != '0) && (wdata != '1);
    end

    assign drop_req = (|partial) && (pend_d == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end
endmodule

// File: rtl/pirq_irq_fsm.sv
`timescale 1ns/1ps
module pirq_irq_fsm
    import pirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic db_hit,
    input  logic drop_req,
    input  logic intx_evt,
    input  logic intx_any,
    output logic irq
);
    irq_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            IRQ_QUIET: begin
                if (db_hit)                                   st_d = IRQ_RAISED;
                else if (!drop_req && intx_evt && intx_any)   st_d = IRQ_RAISED;
            end
            IRQ_RAISED: begin
                if (!db_hit && (drop_req || (intx_evt && !intx_any)))
                    st_d = IRQ_QUIET;
            end
            default: st_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= IRQ_QUIET;
        else        st_q <= st_d;
    end

    always_comb irq = (st_q == IRQ_RAISED);
endmodule

// File: rtl/pirq_aggregator.sv
`timescale 1ns/1ps
module pirq_aggregator #(
    parameter int DW         = 32,
    parameter int NUM_INTX   = 4,
    parameter int MSI_WORDS  = 2,
    localparam int BE_W      = DW / 8,
    localparam int ADDR_W    = $clog2(2 + 2 * MSI_WORDS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_INTX-1:0] intx_lvl,
    input  logic                cfg_done,
    input  logic                db_valid,
    input  logic [BE_W-1:0]     db_be,
    input  logic [DW-1:0]       db_data,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DW-1:0]       reg_wdata,
    output logic [DW-1:0]       reg_rdata,
    output logic                irq
);
    localparam int BIT_W     = $clog2(DW);
    localparam int WSEL_W    = $clog2(MSI_WORDS);
    localparam int VEC_W     = BIT_W + WSEL_W;
    localparam int ST_W      = NUM_INTX + 1;
    localparam int EN_BASE   = 2;
    localparam int PEND_BASE = EN_BASE + MSI_WORDS;

    logic                    db_hit;
    logic                    wr_int_en;
    logic                    wr_int_sts;
    logic [MSI_WORDS-1:0]    wr_msi_en;
    logic [MSI_WORDS-1:0]    wr_msi_pend;
    logic [ST_W-1:0]         int_en_q;
    logic [ST_W-1:0]         int_sts;
    logic [ST_W-1:0]         int_sts_next;
    logic                    intx_evt;
    logic                    intx_any;
    logic [MSI_WORDS*DW-1:0] msi_pend;
    logic                    drop_req;
    logic [DW-1:0]           msi_en_q [MSI_WORDS];

    assign db_hit = db_valid && (&db_be) && (db_data[DW-1:VEC_W] == '0)
                 && (int'(db_data[VEC_W-1:BIT_W]) < MSI_WORDS);

    assign wr_int_en  = reg_wr && (reg_addr == ADDR_W'(0));
    assign wr_int_sts = reg_wr && (reg_addr == ADDR_W'(1));

    for (genvar w = 0; w < MSI_WORDS; w++) begin : g_msi_en
        assign wr_msi_en[w]   = reg_wr && (reg_addr == ADDR_W'(EN_BASE + w));
        assign wr_msi_pend[w] = reg_wr && (reg_addr == ADDR_W'(PEND_BASE + w));
        always_ff @(posedge clk) begin
            if (!rst_n)            msi_en_q[w] <= '0;
            else if (wr_msi_en[w]) msi_en_q[w] <= reg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         int_en_q <= '0;
        else if (wr_int_en) int_en_q <= reg_wdata[ST_W-1:0];
    end

    pirq_intx_status #(.NUM_INTX(NUM_INTX)) u_intx (
        .clk      (clk),
        .rst_n    (rst_n),
        .intx_lvl (intx_lvl),
        .cfg_done (cfg_done),
        .clr_done (wr_int_sts && reg_wdata[NUM_INTX]),
        .sts_q    (int_sts),
        .sts_next (int_sts_next),
        .intx_evt (intx_evt)
    );

    assign intx_any = |(int_sts_next & int_en_q);

    pirq_msi_pending #(.DW(DW), .MSI_WORDS(MSI_WORDS)) u_msi (
        .clk      (clk),
        .rst_n    (rst_n),
        .db_hit   (db_hit),
        .db_vec   (db_data[VEC_W-1:0]),
        .pend_wr  (wr_msi_pend),
        .wdata    (reg_wdata),
        .pend_q   (msi_pend),
        .drop_req (drop_req)
    );

    pirq_irq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .db_hit   (db_hit),
        .drop_req (drop_req),
        .intx_evt (intx_evt),
        .intx_any (intx_any),
        .irq      (irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(0)) reg_rdata = DW'(int_en_q);
        if (reg_addr == ADDR_W'(1)) reg_rdata = DW'(int_sts);
        for (int w = 0; w < MSI_WORDS; w++) begin
            if (reg_addr == ADDR_W'(EN_BASE + w))   reg_rdata = msi_en_q[w];
            if (reg_addr == ADDR_W'(PEND_BASE + w)) reg_rdata = msi_pend[w*DW +: DW];
        end
    end
endmodule

// File: rtl/pirq_aggregator_chk.sv
`timescale 1ns/1ps
module pirq_aggregator_chk #(
    parameter int DW        = 32,
    parameter int NUM_INTX  = 4,
    parameter int MSI_WORDS = 2,
    parameter int ADDR_W    = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NUM_INTX-1:0]     intx_lvl,
    input logic                    cfg_done,
    input logic                    db_valid,
    input logic [DW/8-1:0]         db_be,
    input logic [DW-1:0]           db_data,
    input logic                    reg_wr,
    input logic [ADDR_W-1:0]       reg_addr,
    input logic [DW-1:0]           reg_wdata,
    input logic                    irq,
    input logic [NUM_INTX:0]       int_sts,
    input logic [MSI_WORDS*DW-1:0] msi_pend
);
    localparam int VEC_W     = $clog2(DW) + $clog2(MSI_WORDS);
    localparam int PEND_BASE = 2 + MSI_WORDS;

    logic db_ok;
    logic pend_sel;
    logic sts_sel;

    assign db_ok = db_valid && (&db_be) && (db_data[DW-1:VEC_W] == '0)
                && (int'(db_data[VEC_W-1:0]) < MSI_WORDS * DW);
    assign pend_sel = reg_wr && (int'(reg_addr) >= PEND_BASE)
                   && (int'(reg_addr) < PEND_BASE + MSI_WORDS);
    assign sts_sel  = reg_wr && (int'(reg_addr) == 1);

    a_r2_intx_track: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> int_sts[NUM_INTX-1:0] == $past(intx_lvl));

    a_r4_db_raises: assert property (@(posedge clk) disable iff (!rst_n)
        db_ok |=> irq);

    a_r4_db_sets: assert property (@(posedge clk) disable iff (!rst_n)
        db_ok |=> msi_pend[$past(db_data[VEC_W-1:0])]);

    a_r4_no_stray_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!db_ok && !reg_wr) |=> $stable(msi_pend));

    a_r5_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_sel && reg_wdata[NUM_INTX] && !cfg_done) |=> !int_sts[NUM_INTX]);

    a_r9_done_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> int_sts[NUM_INTX]);

    a_r6_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_sel && (reg_wdata == '0) && !db_ok) |=> $stable(msi_pend));

    a_r7_init_keeps_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_sel && (reg_wdata == '1) && !db_ok
         && (intx_lvl == int_sts[NUM_INTX-1:0])) |=> $stable(irq));
endmodule

bind pirq_aggregator pirq_aggregator_chk #(
    .DW(DW), .NUM_INTX(NUM_INTX), .MSI_WORDS(MSI_WORDS), .ADDR_W(ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .intx_lvl  (intx_lvl),
    .cfg_done  (cfg_done),
    .db_valid  (db_valid),
    .db_be     (db_be),
    .db_data   (db_data),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq       (irq),
    .int_sts   (int_sts),
    .msi_pend  (msi_pend)
);

// File: tb/pirq_aggregator_tb.sv
`timescale 1ns/1ps
module pirq_aggregator_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  intx_lvl = '0;
    logic        cfg_done = 1'b0;
    logic        db_valid = 1'b0;
    logic [3:0]  db_be = '0;
    logic [31:0] db_data = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    always #2 clk = ~clk;   // 250 MHz

    pirq_aggregator u_dut (
        .clk(clk), .rst_n(rst_n), .intx_lvl(intx_lvl), .cfg_done(cfg_done),
        .db_valid(db_valid), .db_be(db_be), .db_data(db_data),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    // Scoreboard queues and trigger
    logic [31:0] exp_data_q [$];
    logic        exp_irq_q  [$];
    logic [2:0]  exp_addr_q [$];
    string       tag_q      [$];
    event        chk_ev;

    // Reference state built from the requirements
    logic [4:0]  m_en;
    logic [4:0]  m_sts;
    logic [31:0] m_pend [2];
    logic [31:0] m_msien [2];
    logic        m_irq;

    function automatic logic [31:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return {27'd0, m_en};
            3'd1: return {27'd0, m_sts};
            3'd2: return m_msien[0];
            3'd3: return m_msien[1];
            3'd4: return m_pend[0];
            3'd5: return m_pend[1];
            default: return 32'd0;
        endcase
    endfunction

    task automatic step(input logic [3:0] ix, input logic dv, input logic [3:0] be,
                        input logic [31:0] dd, input logic wr, input logic [2:0] a,
                        input logic [31:0] wd, input logic dn);
        logic        hit;
        logic        evt;
        logic        partial;
        logic [4:0]  nsts;
        logic [31:0] np [2];
        @(negedge clk);
        intx_lvl = ix; db_valid = dv; db_be = be; db_data = dd;
        reg_wr = wr; reg_addr = a; reg_wdata = wd; cfg_done = dn;
        hit = dv && (be == 4'hF) && (dd < 32'd64);
        evt = (ix != m_sts[3:0]);
        nsts = {(m_sts[4] & ~(wr && a == 3'd1 && wd[4])) | dn, ix};
        for (int w = 0; w < 2; w++) begin
            np[w] = m_pend[w];
            if (wr && a == 3'(4 + w)) np[w] = np[w] & ~wd;
            if (hit && dd[5] == w[0]) np[w] = np[w] | (32'd1 << dd[4:0]);
        end
        partial = wr && (a == 3'd4 || a == 3'd5) && wd != 32'd0 && wd != 32'hFFFF_FFFF;
        if (hit)                                       m_irq = 1'b1;
        else if (partial && np[0] == 0 && np[1] == 0)  m_irq = 1'b0;
        else if (evt)                                  m_irq = |(nsts & m_en);
        if (wr && a == 3'd0) m_en = wd[4:0];
        if (wr && a == 3'd2) m_msien[0] = wd;
        if (wr && a == 3'd3) m_msien[1] = wd;
        m_sts = nsts;
        m_pend[0] = np[0];
        m_pend[1] = np[1];
        @(negedge clk);
        db_valid = 1'b0; db_be = '0; db_data = '0;
        reg_wr = 1'b0; reg_wdata = '0; cfg_done = 1'b0;
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] wd);
        step(intx_lvl, 1'b0, 4'h0, 32'd0, 1'b1, a, wd, 1'b0);
    endtask

    task automatic ring(input logic [31:0] vec, input logic [3:0] be);
        step(intx_lvl, 1'b1, be, vec, 1'b0, 3'd0, 32'd0, 1'b0);
    endtask

    task automatic expect_reg(input logic [2:0] a, input string tag);
        @(negedge clk);
        reg_addr = a;
        exp_addr_q.push_back(a);
        exp_data_q.push_back(model_read(a));
        exp_irq_q.push_back(m_irq);
        tag_q.push_back(tag);
        -> chk_ev;
    endtask

    // Monitor: pops expectations and compares with the outputs
    initial begin
        forever begin
            @(chk_ev);
            #1;
            while (exp_data_q.size() != 0) begin
                logic [31:0] ed;
                logic        ei;
                logic [2:0]  ea;
                string       tg;
                ed = exp_data_q.pop_front();
                ei = exp_irq_q.pop_front();
                ea = exp_addr_q.pop_front();
                tg = tag_q.pop_front();
                checks++;
                if (reg_rdata !== ed || irq !== ei) begin
                    errors++;
                    $display("FAIL %s: sel %0d rdata=%h irq=%b expected rdata=%h irq=%b",
                             tg, ea, reg_rdata, irq, ed, ei);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        m_en = '0; m_sts = '0; m_irq = 1'b0;
        m_pend[0] = '0; m_pend[1] = '0; m_msien[0] = '0; m_msien[1] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of every register and of the line
        for (int a = 0; a < 6; a++) expect_reg(3'(a), "R1");

        // R11: enable registers read back; INT_EN holds bits 4:0 only
        wr_reg(3'd0, 32'hFFFF_FFFF); expect_reg(3'd0, "R11");
        wr_reg(3'd2, 32'hA5A5_0001); expect_reg(3'd2, "R11");
        wr_reg(3'd3, 32'h0000_8000); expect_reg(3'd3, "R11");

        // R2 / R3: INTx tracking and line evaluation
        step(4'b0001, 0, 0, 0, 0, 0, 0, 0); expect_reg(3'd1, "R2");
        step(4'b0000, 0, 0, 0, 0, 0, 0, 0); expect_reg(3'd1, "R3");
        wr_reg(3'd0, 32'h0000_0002);
        step(4'b0100, 0, 0, 0, 0, 0, 0, 0); expect_reg(3'd1, "R3");
        wr_reg(3'd0, 32'h0000_0004); expect_reg(3'd0, "R11");
        step(4'b0101, 0, 0, 0, 0, 0, 0, 0); expect_reg(3'd1, "R3");

        // R5: INTx bits survive a clear-all write; done flag set and clear
        wr_reg(3'd1, 32'hFFFF_FFFF); expect_reg(3'd1, "R5");
        step(4'b0101, 0, 0, 0, 0, 0, 0, 1); expect_reg(3'd1, "R5");
        wr_reg(3'd1, 32'h0000_0010); expect_reg(3'd1, "R5");
        step(4'b0000, 0, 0, 0, 0, 0, 0, 0); expect_reg(3'd1, "R3");

        // R4: doorbells into both words; rejected doorbells
        ring(32'd5, 4'hF);  expect_reg(3'd4, "R4");
        ring(32'd40, 4'hF); expect_reg(3'd5, "R4");
        ring(32'd64, 4'hF); expect_reg(3'd4, "R4"); expect_reg(3'd5, "R4");
        ring(32'd7, 4'h7);  expect_reg(3'd4, "R4");

        // R6: zero write is a no-op
        wr_reg(3'd4, 32'd0); expect_reg(3'd4, "R6");
        // R7: all-ones clears the word, line stays high
        wr_reg(3'd5, 32'hFFFF_FFFF); expect_reg(3'd5, "R7");
        // R8: partial clear with the other word pending keeps the line
        ring(32'd33, 4'hF);
        wr_reg(3'd4, 32'h0000_0020); expect_reg(3'd4, "R8");
        wr_reg(3'd5, 32'h0000_0002); expect_reg(3'd5, "R8");

        // R9: set wins over same-cycle clear
        step(4'b0000, 1, 4'hF, 32'd3, 1, 3'd4, 32'h0000_0008, 0); expect_reg(3'd4, "R9");
        step(4'b0000, 0, 0, 0, 1, 3'd1, 32'h0000_0010, 1);       expect_reg(3'd1, "R9");

        // R10: MSI drop beats INTx re-evaluation; doorbell beats INTx low
        wr_reg(3'd0, 32'h0000_0010);
        step(4'b0010, 0, 0, 0, 1, 3'd4, 32'h0000_0008, 0); expect_reg(3'd4, "R10");
        wr_reg(3'd1, 32'h0000_0010);
        step(4'b0000, 1, 4'hF, 32'd0, 0, 0, 0, 0); expect_reg(3'd4, "R10");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule